// File: doc/BRIEF.md
# Illegal Instruction Exception Entry

This block sits beside the instruction decoder of a 32-bit core. For each decoded instruction it receives a set of classification flags, the raw 16-bit opcode and the current architectural context (program counter, status register, stack register R15 and vector base). From these it decides whether the instruction raises a general illegal-instruction exception. When it does, the block performs the whole entry sequence on a single clock edge. It saves the context, loads the event code, forces the mode bits of the status register and redirects the program counter to the vector. It also keeps track of whether the next instruction sits in the delay slot of a delayed branch, because the exception is never raised from inside a slot.

The decoder presents one instruction per cycle, qualified by `dec_valid`. The block is always able to accept an instruction and never applies back-pressure, so no ready signal exists. A cycle with `dec_valid` low carries no instruction. The registered outputs `new_pc` and `new_sr` are intended to be written into the core's PC and SR whenever `exc_pulse` is high.

Top module: `illx_entry`

## Requirements
- R1: After reset, `exc_pulse` and `in_slot` are 0 and all saved-context, event-code, `new_sr` and `new_pc` outputs are 0.
- R2: A valid instruction outside a delay slot traps if `dec_undef` is high, or if its opcode equals 0xFFFD regardless of the flags. In that case `exc_pulse` is high in the cycle after the edge that sampled it.
- R3: A valid instruction outside a delay slot with `dec_priv` high and `dec_gbr_ctl` low traps when `cur_sr` bit 30 (the mode bit) is 0, which is user mode. It does not trap when that bit is 1. The mode bit is taken from `cur_sr` as presented, before any entry update.
- R4: A privileged instruction flagged with `dec_gbr_ctl` high, meaning a control-register move targeting GBR, does not trap in either mode.
- R5: A valid delayed branch (`dec_branch` high) that does not trap opens a delay slot, and `in_slot` reads 1 from the next cycle. The slot covers exactly the next valid instruction, and no instruction in it traps. A delayed branch inside a slot does not open another slot. Exception entry leaves `in_slot` at 0.
- R6: On entry, `saved_pc`, `saved_sr` and `saved_r15` take the values of `cur_pc`, `cur_sr` and `cur_r15` of the trapping instruction.
- R7: On entry, `exc_code` becomes 0x00000180.
- R8: On entry, `new_sr` equals the trapping instruction's `cur_sr` with bits 30 (mode), 29 (register bank) and 28 (block) set to 1. All other bits are unchanged.
- R9: On entry, `new_pc` equals `cur_vbr` + 0x100.
- R10: `exc_pulse` is high for one cycle per trapping instruction. The saved-context, event-code, `new_sr` and `new_pc` outputs change only on an entry edge and hold otherwise.
- R11: A cycle with `dec_valid` low never traps and leaves `in_slot` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | An instruction is presented this cycle |
| dec_undef | input | 1 | Decoder marks the opcode undefined |
| dec_priv | input | 1 | Decoder marks the opcode privileged |
| dec_branch | input | 1 | Decoder marks the opcode a delayed branch |
| dec_gbr_ctl | input | 1 | Privileged form is a control-register move targeting GBR |
| dec_opcode | input | 16 | Raw opcode |
| cur_pc | input | 32 | PC of the presented instruction |
| cur_sr | input | 32 | Current status register |
| cur_r15 | input | 32 | Current R15 |
| cur_vbr | input | 32 | Vector base |
| exc_pulse | output | 1 | One-cycle strobe marking exception entry |
| in_slot | output | 1 | The next valid instruction occupies a delay slot |
| saved_pc | output | 32 | Saved PC |
| saved_sr | output | 32 | Saved SR |
| saved_r15 | output | 32 | Saved R15 |
| exc_code | output | 32 | Exception event code |
| new_sr | output | 32 | SR value to install on entry |
| new_pc | output | 32 | PC value to install on entry |

## Verification
The assertions assume that the decoder flags are meaningful only while `dec_valid` is high and that the context inputs describe the instruction presented in that cycle. They place no constraint on flag combinations, so an undefined, privileged and branch flag may appear together. The random stimulus keeps to one instruction per cycle and lets any flag mix occur. It raises the rate of the 0xFFFD opcode and of delayed branches so that slot boundaries and the forced trap code are reached often. Directed sequences cover a trap attempt inside a slot, the GBR exemption in user mode and idle cycles inside an open slot.

// File: rtl/illx_pkg.sv
package illx_pkg;
  localparam int unsigned XLEN       = 32;
  localparam int unsigned ILEN       = 16;
  localparam int unsigned MD_POS     = 30;
  localparam int unsigned RB_POS     = 29;
  localparam int unsigned BL_POS     = 28;
  localparam logic [15:0] TRAP_OP    = 16'hFFFD;
  localparam logic [31:0] EVT_ILLEGAL = 32'h0000_0180;
  localparam logic [31:0] VEC_OFFSET = 32'h0000_0100;

  typedef struct packed {
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] sr;
    logic [XLEN-1:0] r15;
    logic [XLEN-1:0] vbr;
  } ctx_t;
endpackage

// File: rtl/illx_detect.sv
module illx_detect #(
  parameter int unsigned ILEN    = 16,
  parameter int unsigned XLEN    = 32,
  parameter int unsigned MD_POS  = 30,
  parameter logic [ILEN-1:0] TRAP_OP = '1
) (
  input  logic            valid,
  input  logic            undef,
  input  logic            priv,
  input  logic            gbr_ctl,
  input  logic [ILEN-1:0] opcode,
  input  logic [XLEN-1:0] sr,
  input  logic            slot,
  output logic            take
);
  logic undef_hit;
  logic priv_hit;
  logic user_mode;

  always_comb begin
    user_mode = ~sr[MD_POS];
    undef_hit = undef | (opcode == TRAP_OP);
    priv_hit  = priv & ~gbr_ctl & user_mode;
    take      = valid & ~slot & (undef_hit | priv_hit);
  end
endmodule

// File: rtl/illx_slot.sv
module illx_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic branch,
  input  logic take,
  output logic slot
);
  logic slot_d;

  always_comb begin
    slot_d = slot;
    if (take)
      slot_d = 1'b0;
    else if (valid)
      slot_d = branch & ~slot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) slot <= 1'b0;
    else        slot <= slot_d;
  end
endmodule

// File: rtl/illx_regs.sv
module illx_regs
  import illx_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned MD_BIT  = 30,
  parameter int unsigned RB_BIT  = 29,
  parameter int unsigned BL_BIT  = 28,
  parameter logic [W-1:0] CODE   = 32'h180,
  parameter logic [W-1:0] OFFSET = 32'h100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  ctx_t         ctx,
  output logic         pulse,
  output logic [W-1:0] spc,
  output logic [W-1:0] ssr,
  output logic [W-1:0] sgr,
  output logic [W-1:0] evt,
  output logic [W-1:0] sr_o,
  output logic [W-1:0] pc_o
);
  localparam logic [W-1:0] SET_MASK =
    (W'(1) << MD_BIT) | (W'(1) << RB_BIT) | (W'(1) << BL_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      spc   <= '0;
      ssr   <= '0;
      sgr   <= '0;
      evt   <= '0;
      sr_o  <= '0;
      pc_o  <= '0;
    end else begin
      pulse <= take;
      if (take) begin
        spc  <= ctx.pc;
        ssr  <= ctx.sr;
        sgr  <= ctx.r15;
        evt  <= CODE;
        sr_o <= ctx.sr | SET_MASK;
        pc_o <= ctx.vbr + OFFSET;
      end
    end
  end
endmodule

// File: rtl/illx_entry.sv
module illx_entry
  import illx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  input  logic            dec_undef,
  input  logic            dec_priv,
  input  logic            dec_branch,
  input  logic            dec_gbr_ctl,
  input  logic [ILEN-1:0] dec_opcode,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_sr,
  input  logic [XLEN-1:0] cur_r15,
  input  logic [XLEN-1:0] cur_vbr,
  output logic            exc_pulse,
  output logic            in_slot,
  output logic [XLEN-1:0] saved_pc,
  output logic [XLEN-1:0] saved_sr,
  output logic [XLEN-1:0] saved_r15,
  output logic [XLEN-1:0] exc_code,
  output logic [XLEN-1:0] new_sr,
  output logic [XLEN-1:0] new_pc
);
  logic take;
  ctx_t ctx;

  assign ctx = '{pc: cur_pc, sr: cur_sr, r15: cur_r15, vbr: cur_vbr};

  illx_detect #(
    .ILEN(ILEN), .XLEN(XLEN), .MD_POS(MD_POS), .TRAP_OP(TRAP_OP)
  ) detect_i (
    .valid(dec_valid), .undef(dec_undef), .priv(dec_priv),
    .gbr_ctl(dec_gbr_ctl), .opcode(dec_opcode), .sr(cur_sr),
    .slot(in_slot), .take(take)
  );

  illx_slot slot_i (
    .clk(clk), .rst_n(rst_n), .valid(dec_valid),
    .branch(dec_branch), .take(take), .slot(in_slot)
  );

  illx_regs #(
    .W(XLEN), .MD_BIT(MD_POS), .RB_BIT(RB_POS), .BL_BIT(BL_POS),
    .CODE(EVT_ILLEGAL), .OFFSET(VEC_OFFSET)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .take(take), .ctx(ctx),
    .pulse(exc_pulse), .spc(saved_pc), .ssr(saved_sr), .sgr(saved_r15),
    .evt(exc_code), .sr_o(new_sr), .pc_o(new_pc)
  );
endmodule

// File: rtl/illx_entry_chk.sv
module illx_entry_chk
  import illx_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            dec_valid,
  input logic            dec_undef,
  input logic            dec_priv,
  input logic            dec_gbr_ctl,
  input logic [ILEN-1:0] dec_opcode,
  input logic [XLEN-1:0] cur_pc,
  input logic [XLEN-1:0] cur_sr,
  input logic [XLEN-1:0] cur_vbr,
  input logic            exc_pulse,
  input logic            in_slot,
  input logic [XLEN-1:0] saved_pc,
  input logic [XLEN-1:0] saved_sr,
  input logic [XLEN-1:0] exc_code,
  input logic [XLEN-1:0] new_sr,
  input logic [XLEN-1:0] new_pc
);
  // R2: the reserved trap opcode outside a slot always enters
  p_trap_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !in_slot && dec_opcode == TRAP_OP) |=> exc_pulse);

  // R4: a GBR-targeting privileged move that is otherwise legal never enters
  p_gbr_exempt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_priv && dec_gbr_ctl && !dec_undef && dec_opcode != TRAP_OP)
      |=> !exc_pulse);

  // R5: nothing inside a slot enters, and entry leaves the slot closed
  p_no_slot_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_slot |=> !exc_pulse);
  p_slot_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |-> !in_slot);

  // R6: saved PC and SR come from the trapping instruction
  p_save_ctx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |-> (saved_pc == $past(cur_pc) && saved_sr == $past(cur_sr)));

  // R7: event code
  p_evt_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |-> exc_code == EVT_ILLEGAL);

  // R8: mode, bank and block bits forced
  p_sr_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |-> (new_sr[MD_POS] && new_sr[RB_POS] && new_sr[BL_POS]));

  // R9: vector target
  p_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |-> new_pc == $past(cur_vbr) + VEC_OFFSET);

  // R10: outputs hold between entries
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_pulse |-> ($stable(saved_pc) && $stable(new_pc) && $stable(new_sr)));

  // R11: an idle cycle neither enters nor moves the slot flag
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> (!exc_pulse && in_slot == $past(in_slot)));
endmodule

bind illx_entry illx_entry_chk chk_i (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_undef(dec_undef),
  .dec_priv(dec_priv), .dec_gbr_ctl(dec_gbr_ctl), .dec_opcode(dec_opcode),
  .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_vbr(cur_vbr),
  .exc_pulse(exc_pulse), .in_slot(in_slot), .saved_pc(saved_pc),
  .saved_sr(saved_sr), .exc_code(exc_code), .new_sr(new_sr), .new_pc(new_pc)
);

// File: tb/illx_entry_tb_top.sv
module illx_entry_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 0, dec_undef = 0, dec_priv = 0, dec_branch = 0, dec_gbr_ctl = 0;
  logic [15:0] dec_opcode = '0;
  logic [31:0] cur_pc = '0, cur_sr = '0, cur_r15 = '0, cur_vbr = '0;
  logic exc_pulse, in_slot;
  logic [31:0] saved_pc, saved_sr, saved_r15, exc_code, new_sr, new_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected state
  logic m_pulse = 0, m_slot = 0;
  logic [31:0] m_spc = 0, m_ssr = 0, m_sgr = 0, m_evt = 0, m_sr = 0, m_pc = 0;
  string m_tag = "R1";

  always #2.5 clk = ~clk;

  illx_entry dut_i (.*);

  function automatic bit f_trap(bit v, bit s, bit u, bit p, bit g,
                                logic [15:0] op, logic [31:0] sr);
    return v && !s && (u || op == 16'hFFFD || (p && !g && !sr[30]));
  endfunction

  function automatic string f_tag(bit v, bit s, bit u, bit p, bit g, logic [15:0] op);
    if (!v) return "R11";
    if (s) return "R5";
    if (u || op == 16'hFFFD) return "R2";
    if (p && g) return "R4";
    return "R3";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(m_tag, {31'd0, exc_pulse}, {31'd0, m_pulse});
    chk(m_pulse ? "R5" : "R5_slot", {31'd0, in_slot}, {31'd0, m_slot});
    chk("R6", saved_pc, m_spc);
    chk("R6", saved_sr, m_ssr);
    chk("R6", saved_r15, m_sgr);
    chk(m_pulse ? "R7" : "R10", exc_code, m_evt);
    chk(m_pulse ? "R8" : "R10", new_sr, m_sr);
    chk(m_pulse ? "R9" : "R10", new_pc, m_pc);
  endtask

  // drive at negedge, compute expectation, check at next negedge
  task automatic step(bit v, bit u, bit p, bit b, bit g, logic [15:0] op,
                      logic [31:0] pc, logic [31:0] sr);
    bit t;
    dec_valid = v; dec_undef = u; dec_priv = p; dec_branch = b; dec_gbr_ctl = g;
    dec_opcode = op; cur_pc = pc; cur_sr = sr;
    cur_r15 = pc ^ 32'h5A5A_0000; cur_vbr = {pc[31:8], 8'h00};
    t = f_trap(v, m_slot, u, p, g, op, sr);
    m_tag = f_tag(v, m_slot, u, p, g, op);
    m_pulse = t;
    if (t) begin
      m_spc = pc; m_ssr = sr; m_sgr = cur_r15; m_evt = 32'h180;
      m_sr = sr | 32'h7000_0000; m_pc = cur_vbr + 32'h100;
      m_slot = 0;
    end else if (v) begin
      m_slot = b && !m_slot;
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state (first sample after reset release, idle input)
    chk("R1", {31'd0, exc_pulse}, 32'd0);
    chk("R1", {31'd0, in_slot}, 32'd0);
    chk("R1", saved_pc | saved_sr | saved_r15 | exc_code | new_sr | new_pc, 32'd0);

    // R2: forced trap opcode with no flags
    step(1, 0, 0, 0, 0, 16'hFFFD, 32'h0000_1000, 32'h0000_00F0);
    // R3: privileged in user mode traps, supervisor does not
    step(1, 0, 1, 0, 0, 16'h4E0E, 32'h0000_2000, 32'h0000_0001);
    step(1, 0, 1, 0, 0, 16'h4E0E, 32'h0000_2002, 32'h4000_0001);
    // R4: GBR form exempt in user mode
    step(1, 0, 1, 0, 1, 16'h401E, 32'h0000_3000, 32'h0000_0000);
    // R5: branch, then trap opcode in slot, then trap opcode after slot
    step(1, 0, 0, 1, 0, 16'hA010, 32'h0000_4000, 32'h0000_0000);
    step(0, 1, 0, 0, 0, 16'hFFFD, 32'h0000_4002, 32'h0000_0000); // R11 idle keeps slot
    step(1, 0, 0, 1, 0, 16'hFFFD, 32'h0000_4002, 32'h0000_0000);
    step(1, 0, 0, 0, 0, 16'hFFFD, 32'h0000_4004, 32'h0000_0000);
    // R5: trapping branch (user RTE) opens no slot
    step(1, 0, 1, 1, 0, 16'h002B, 32'h0000_5000, 32'h0000_0000);
    step(1, 1, 0, 0, 0, 16'h1234, 32'h0000_5002, 32'h0000_0000);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic [15:0] op;
      r = $urandom;
      op = (r[3:0] == 0) ? 16'hFFFD : 16'($urandom);
      step(r[4:3] != 0, r[9:6] == 0, r[12:10] == 0, r[15:13] < 2, r[16],
           op, {$urandom} & 32'hFFFF_FFFE, $urandom);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule